// File: doc/BRIEF.md
# PLL configuration register bank

This block is the byte-wide register bank for a clock generator's PLL. It holds an 8-bit VCO range multiplier and a 4-bit reference divider select, each at its own bus address, with the divider one address above the multiplier. It drives both values to the PLL as configuration outputs. It also holds the base clock select bit, which chooses between the reference clock and the VCO as the base clock. The PLL-on request comes in from the control logic as an input.

The bank keeps the PLL configuration consistent. While the PLL is on, neither the multiplier nor the divider can be changed. A multiplier of zero turns the PLL off: the enable output drops, the clock select is forced back to the reference, and the select cannot be set again while the multiplier stays zero. Reads are combinational from the address. Writes take effect on the rising clock edge. A synchronous active-high reset restores all state.

Top module: `pll_cfg_bank`

## Requirements
- R1: On synchronous reset the multiplier reads 0x40, the divider reads 0x01, the clock select is 0 and the PLL enable output is 0.
- R2: A write to BASE_ADDR while `pllOnIn` is 0 loads all 8 data bits into the multiplier on the next rising edge.
- R3: A write to BASE_ADDR while `pllOnIn` is 1 leaves the multiplier unchanged.
- R4: A write to BASE_ADDR+1 while `pllOnIn` is 0 stores data bits [3:0] in the divider. A read of BASE_ADDR+1 returns the divider in bits [3:0] and zero in bits [7:4].
- R5: A write to BASE_ADDR+1 while `pllOnIn` is 1 leaves the divider unchanged.
- R6: `pllEnable` is 1 exactly when `pllOnIn` is 1 and the multiplier is nonzero.
- R7: The clock select is 0 in every cycle in which the multiplier holds 0x00. A write that makes the multiplier zero clears the select on the same edge, even if a select-set request arrives in the same cycle. A select-set that arrives with a write of a nonzero multiplier is evaluated against the new value.
- R8: A select write with value 1 sets `baseSelVco` only if the multiplier after that edge is nonzero. A select write with value 0 always clears it.
- R9: A write to any address other than BASE_ADDR and BASE_ADDR+1 changes no state. A read from such an address returns 0x00.
- R10: `rdData` shows the register at `addr` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus address |
| wrData | input | DATA_W | Bus write data |
| rdData | output | DATA_W | Bus read data for `addr` |
| pllOnIn | input | 1 | PLL-on request from the control logic |
| selWrEn | input | 1 | Write strobe for the base clock select |
| selWrVal | input | 1 | Value requested for the base clock select |
| vcoRange | output | DATA_W | Current VCO range multiplier |
| refDiv | output | DIV_W | Current reference divider select |
| pllEnable | output | 1 | Effective PLL enable |
| baseSelVco | output | 1 | Base clock select: 1 = VCO, 0 = reference |

## Verification
A multiplier write and a clock-select write can land on the same edge, and their outcome depends on which multiplier value the select is judged against. The bench provokes this case twice: once with a write of 0x00 together with a select-set, which must leave the select clear, and once with a write of a nonzero value out of a zero multiplier together with a select-set, which must set it. Both results are read from the outputs one edge later.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  // Strobes from the decode/control side to the register datapath
  typedef struct packed {
    logic rangeWr;  // load multiplier (already gated by lock)
    logic divWr;    // load divider (already gated by lock)
    logic selWr;    // clock-select write request
    logic rdRange;  // address hits multiplier
    logic rdDiv;    // address hits divider
  } cfg_strobe_t;
endpackage

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pllOnIn,
  input  logic              selWrEn,
  output cfg_strobe_t       strobe
);
  localparam logic [ADDR_W-1:0] DIV_ADDR = BASE_ADDR + 1'b1;

  logic hitRange;
  logic hitDiv;
  logic unlocked;

  always_comb begin
    hitRange = (addr == BASE_ADDR);
    hitDiv   = (addr == DIV_ADDR);
    unlocked = !pllOnIn;
    strobe.rangeWr = wrEn && hitRange && unlocked;
    strobe.divWr   = wrEn && hitDiv && unlocked;
    strobe.selWr   = selWrEn;
    strobe.rdRange = hitRange;
    strobe.rdDiv   = hitDiv;
  end
endmodule

// File: rtl/pll_cfg_dp.sv
module pll_cfg_dp
  import pll_cfg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 4,
  parameter logic [DATA_W-1:0] RANGE_RST = 8'h40,
  parameter logic [DIV_W-1:0] DIV_RST = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pllOnIn,
  input  logic              selWrVal,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] vcoRange,
  output logic [DIV_W-1:0]  refDiv,
  output logic              pllEnable,
  output logic              baseSelVco
);
  localparam int PAD_W = DATA_W - DIV_W;

  logic [DATA_W-1:0] rangeQ, rangeNext;
  logic [DIV_W-1:0]  divQ, divNext;
  logic              selQ, selNext;
  logic              rangeNextZero;
  logic [DATA_W-1:0] divRead;

  always_comb begin
    rangeNext     = strobe.rangeWr ? wrData : rangeQ;
    divNext       = strobe.divWr ? wrData[DIV_W-1:0] : divQ;
    rangeNextZero = (rangeNext == '0);
    if (rangeNextZero)     selNext = 1'b0;
    else if (strobe.selWr) selNext = selWrVal;
    else                   selNext = selQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rangeQ <= RANGE_RST;
      divQ   <= DIV_RST;
      selQ   <= 1'b0;
    end else begin
      rangeQ <= rangeNext;
      divQ   <= divNext;
      selQ   <= selNext;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign divRead = {{PAD_W{1'b0}}, divQ};
    end else begin : g_nopad
      assign divRead = divQ[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    if (strobe.rdRange)    rdData = rangeQ;
    else if (strobe.rdDiv) rdData = divRead;
    else                   rdData = '0;
  end

  assign vcoRange   = rangeQ;
  assign refDiv     = divQ;
  assign pllEnable  = pllOnIn && (rangeQ != '0);
  assign baseSelVco = selQ;
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DIV_W = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
  parameter logic [DATA_W-1:0] RANGE_RST = 8'h40,
  parameter logic [DIV_W-1:0] DIV_RST = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              pllOnIn,
  input  logic              selWrEn,
  input  logic              selWrVal,
  output logic [DATA_W-1:0] vcoRange,
  output logic [DIV_W-1:0]  refDiv,
  output logic              pllEnable,
  output logic              baseSelVco
);
  cfg_strobe_t strobe;

  pll_cfg_ctrl #(
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .wrEn(wrEn),
    .addr(addr),
    .pllOnIn(pllOnIn),
    .selWrEn(selWrEn),
    .strobe(strobe)
  );

  pll_cfg_dp #(
    .DATA_W(DATA_W),
    .DIV_W(DIV_W),
    .RANGE_RST(RANGE_RST),
    .DIV_RST(DIV_RST)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .wrData(wrData),
    .pllOnIn(pllOnIn),
    .selWrVal(selWrVal),
    .rdData(rdData),
    .vcoRange(vcoRange),
    .refDiv(refDiv),
    .pllEnable(pllEnable),
    .baseSelVco(baseSelVco)
  );
endmodule

// File: rtl/pll_cfg_bank_chk.sv
module pll_cfg_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DIV_W = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
  parameter logic [DATA_W-1:0] RANGE_RST = 8'h40,
  parameter logic [DIV_W-1:0] DIV_RST = 4'h1
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              pllOnIn,
  input logic [DATA_W-1:0] vcoRange,
  input logic [DIV_W-1:0]  refDiv,
  input logic              pllEnable,
  input logic              baseSelVco
);
  localparam logic [ADDR_W-1:0] DIV_ADDR = BASE_ADDR + 1'b1;

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vcoRange == RANGE_RST && refDiv == DIV_RST && !baseSelVco));

  // R3
  range_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && pllOnIn && addr == BASE_ADDR) |=> $stable(vcoRange));

  // R5
  div_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && pllOnIn && addr == DIV_ADDR) |=> $stable(refDiv));

  // R4
  div_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == DIV_ADDR) |-> (rdData[DATA_W-1:DIV_W] == '0));

  // R6
  zero_range_off_chk: assert property (@(posedge clk) disable iff (rst)
    (vcoRange == '0) |-> !pllEnable);

  // R7
  zero_range_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (vcoRange == '0) |-> !baseSelVco);

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr != BASE_ADDR && addr != DIV_ADDR) |=> ($stable(vcoRange) && $stable(refDiv)));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (addr != BASE_ADDR && addr != DIV_ADDR) |-> (rdData == '0));
endmodule

bind pll_cfg_bank pll_cfg_bank_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .DIV_W(DIV_W),
  .BASE_ADDR(BASE_ADDR),
  .RANGE_RST(RANGE_RST),
  .DIV_RST(DIV_RST)
) u_chk (
  .clk(clk),
  .rst(rst),
  .wrEn(wrEn),
  .addr(addr),
  .rdData(rdData),
  .pllOnIn(pllOnIn),
  .vcoRange(vcoRange),
  .refDiv(refDiv),
  .pllEnable(pllEnable),
  .baseSelVco(baseSelVco)
);

// File: tb/pll_cfg_bank_tb.sv
module pll_cfg_bank_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       pllOnIn = 1'b0;
  logic       selWrEn = 1'b0;
  logic       selWrVal = 1'b0;
  logic [7:0] vcoRange;
  logic [3:0] refDiv;
  logic       pllEnable;
  logic       baseSelVco;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  pll_cfg_bank u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pllOnIn(pllOnIn), .selWrEn(selWrEn), .selWrVal(selWrVal),
    .vcoRange(vcoRange), .refDiv(refDiv), .pllEnable(pllEnable),
    .baseSelVco(baseSelVco)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] a;
    logic [7:0] d;
    logic       on;
    logic       sw;
    logic       sv;
    logic [7:0] eR;
    logic [3:0] eD;
    logic       eS;
    logic       eE;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h10, 8'h5A, 1'b0, 1'b0, 1'b0, 8'h5A, 4'h1, 1'b0, 1'b0, 8'd2},  // R2 load multiplier
    '{1'b1, 8'h11, 8'hF3, 1'b0, 1'b0, 1'b0, 8'h5A, 4'h3, 1'b0, 1'b0, 8'd4},  // R4 low nibble only
    '{1'b0, 8'h10, 8'h00, 1'b1, 1'b0, 1'b0, 8'h5A, 4'h3, 1'b0, 1'b1, 8'd6},  // R6 enable with nonzero
    '{1'b1, 8'h10, 8'h22, 1'b1, 1'b0, 1'b0, 8'h5A, 4'h3, 1'b0, 1'b1, 8'd3},  // R3 locked multiplier
    '{1'b1, 8'h11, 8'h07, 1'b1, 1'b0, 1'b0, 8'h5A, 4'h3, 1'b0, 1'b1, 8'd5},  // R5 locked divider
    '{1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 8'h5A, 4'h3, 1'b1, 1'b0, 8'd8},  // R8 set select
    '{1'b1, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'h3, 1'b0, 1'b0, 8'd7},  // R7 zero clears select
    '{1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 4'h3, 1'b0, 1'b0, 8'd8},  // R8 set refused
    '{1'b0, 8'h10, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'h3, 1'b0, 1'b0, 8'd6},  // R6 zero disables
    '{1'b1, 8'h10, 8'h81, 1'b0, 1'b1, 1'b1, 8'h81, 4'h3, 1'b1, 1'b0, 8'd7},  // R7 collision nonzero
    '{1'b1, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 4'h3, 1'b0, 1'b0, 8'd7},  // R7 collision zero
    '{1'b1, 8'h12, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00, 4'h3, 1'b0, 1'b0, 8'd9},  // R9 above map
    '{1'b1, 8'h0F, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00, 4'h3, 1'b0, 1'b0, 8'd9},  // R9 below map
    '{1'b1, 8'h10, 8'hC3, 1'b0, 1'b0, 1'b0, 8'hC3, 4'h3, 1'b0, 1'b0, 8'd2},  // R2 reload
    '{1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 8'hC3, 4'h3, 1'b1, 1'b0, 8'd8},  // R8 set again
    '{1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 1'b0, 8'hC3, 4'h3, 1'b0, 1'b0, 8'd8}   // R8 clear
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input logic [7:0] eR, input logic [3:0] eD,
                          input logic eS, input logic eE);
    chk({tag, " range"}, 32'(vcoRange), 32'(eR));
    chk({tag, " div"}, 32'(refDiv), 32'(eD));
    chk({tag, " sel"}, 32'(baseSelVco), 32'(eS));
    chk({tag, " en"}, 32'(pllEnable), 32'(eE));
  endtask

  task automatic idle();
    wrEn = 1'b0; selWrEn = 1'b0; selWrVal = 1'b0; pllOnIn = 1'b0;
  endtask

  task automatic readAt(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    idle();
    addr = a;
    #2;
    chk(tag, 32'(rdData), 32'(exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 state after reset
    chkState("R1 reset", 8'h40, 4'h1, 1'b0, 1'b0);
    readAt("R1 read multiplier", 8'h10, 8'h40);
    readAt("R1 read divider", 8'h11, 8'h01);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = VECS[i].we; addr = VECS[i].a; wrData = VECS[i].d;
      pllOnIn = VECS[i].on; selWrEn = VECS[i].sw; selWrVal = VECS[i].sv;
      @(posedge clk);
      #5;
      chkState($sformatf("R%0d vec%0d", VECS[i].req, i),
               VECS[i].eR, VECS[i].eD, VECS[i].eS, VECS[i].eE);
    end

    // R10 combinational reads; R4 upper nibble zero; R9 unmapped reads
    readAt("R10 read multiplier", 8'h10, 8'hC3);
    readAt("R4 read divider", 8'h11, 8'h03);
    readAt("R9 read above", 8'h12, 8'h00);
    readAt("R9 read below", 8'h0F, 8'h00);

    // R6 live enable follows pllOnIn without delay
    @(negedge clk);
    idle();
    pllOnIn = 1'b1;
    #2;
    chk("R6 enable live", 32'(pllEnable), 32'd1);

    // R1 mid-run reset with pending write
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b1; addr = 8'h10; wrData = 8'h99; pllOnIn = 1'b0;
    selWrEn = 1'b1; selWrVal = 1'b1;
    @(posedge clk);
    #5;
    chkState("R1 reset again", 8'h40, 4'h1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    idle();
    readAt("R1 read after reset", 8'h11, 8'h01);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule